// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO Register Block

This block sits between a processor bus and the shift engine of an SPI master. It holds one queue of outgoing data items and one of incoming data items, each up to 16 bits wide. Software fills the transmit queue through a transmit data register and drains the receive queue through a receive data register. The engine takes transmit items through a pop interface and delivers received items through a push interface. A full 32-bit write to the transmit data register enqueues two items in one access. A halfword write enqueues one.

Software sets a receive threshold so that one interrupt announces a whole burst, and a transmit threshold that reports when the transmit queue has drained. Sticky event flags record threshold crossings, dropped pushes, reads from an empty queue and receive overruns. A status read clears them. Any enabled sticky flag drives the interrupt line. The queues are off after reset, and each then behaves as a single holding register. A command turns on full queue depth.

Register map (byte offsets): 0x00 command (write), 0x04 queue mode, 0x08 status, 0x0C levels, 0x10 interrupt enable set, 0x14 interrupt enable clear, 0x18 interrupt enable read-back, 0x1C transmit data, 0x20 receive data. Reads of write-only or unused offsets return zero.

Top module: `spi_fifo_regs`

## Requirements
- R1: A 32-bit write (bus_half=0) to transmit data enqueues bits 15:0 and then bits 31:16. A halfword write (bus_half=1) enqueues bits 15:0 only. The engine sees the oldest item on eng_tx_data with eng_tx_valid high, and eng_tx_pop removes it.
- R2: eng_rx_push enqueues eng_rx_data. Each read of receive data removes the oldest item and returns it in bits 15:0, with bits 31:16 zero.
- R3: A command write with bit 16 set empties the transmit queue, and one with bit 17 set empties the receive queue. The level takes effect on the next cycle.
- R4: Command bit 30 selects full depth and command bit 31 selects single-entry capacity, with bit 31 winning if both are set. Either command empties both queues. After reset, capacity is one entry.
- R5: The level register reports the transmit level in bits 5:0 and the receive level in bits 21:16. All other bits read zero.
- R6: The mode register stores the transmit-ready mode in bits 1:0, the receive-ready mode in bits 5:4, the transmit threshold in bits 21:16 and the receive threshold in bits 29:24. All other bits read zero. Mode is zero after reset.
- R7: Status shows live flags: transmit empty at bit 24, transmit full at bit 25, receive empty at bit 27 and receive full at bit 28. After reset, status reads 0x09000000.
- R8: Status bit 29 is set when the receive level rises from below a nonzero receive threshold to or above it. Status bit 26 is set when the transmit level falls from above the transmit threshold to or below it. Both flags are sticky.
- R9: An enqueue to a full transmit queue is dropped and sets sticky bit 30. A 32-bit write that finds one free slot keeps the low half and drops the high half.
- R10: A read of receive data while the receive queue is empty returns zero and sets sticky bit 31.
- R11: An engine push into a full receive queue is discarded and sets sticky overrun bit 3.
- R12: A status read clears sticky bits 3, 26, 29, 30 and 31. A new event in the same cycle survives.
- R13: Writing ones to interrupt-enable-set enables those of bits 3, 26, 29, 30 and 31. Writing ones to interrupt-enable-clear disables them. The read-back returns the enables. irq is high when any enabled sticky flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_half | input | 1 | Write is a halfword (bits 15:0 only) |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (side effects at clock edge) |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| eng_tx_valid | output | 1 | Transmit queue holds an item |
| eng_tx_data | output | 16 | Oldest transmit item, zero when empty |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit item |
| eng_rx_push | input | 1 | Engine delivers a received item |
| eng_rx_data | input | 16 | Received item |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that a queue never holds more than its current capacity, that a level never falls without a pop or a clear, that clear commands empty a queue on the next edge, and that dropped pushes, empty reads and overruns raise their sticky flags. Other behaviour can only be shown by the bench's scenarios. These are the item ordering across halfword and 32-bit writes, the exact register layouts, threshold crossings in both directions, read-to-clear precedence, and the interrupt following its enables. The bench sweeps every fill level of a four-entry configuration in both directions.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_MODE  = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_LVL   = 8'h0C;
    localparam logic [7:0] OFS_IESET = 8'h10;
    localparam logic [7:0] OFS_IECLR = 8'h14;
    localparam logic [7:0] OFS_IEVAL = 8'h18;
    localparam logic [7:0] OFS_TXD   = 8'h1C;
    localparam logic [7:0] OFS_RXD   = 8'h20;

    localparam int CMD_TXCLR = 16;
    localparam int CMD_RXCLR = 17;
    localparam int CMD_ON    = 30;
    localparam int CMD_OFF   = 31;

    localparam int ST_OVR    = 3;
    localparam int ST_TXEMP  = 24;
    localparam int ST_TXFUL  = 25;
    localparam int ST_TXTHR  = 26;
    localparam int ST_RXEMP  = 27;
    localparam int ST_RXFUL  = 28;
    localparam int ST_RXTHR  = 29;
    localparam int ST_TXPTR  = 30;
    localparam int ST_RXPTR  = 31;

    localparam logic [31:0] STICKY_BITS = 32'hE400_0008;

    typedef struct packed {
        logic [5:0] rx_thr;
        logic [5:0] tx_thr;
        logic [1:0] rx_rdy_mode;
        logic [1:0] tx_rdy_mode;
    } mode_t;

endpackage

// File: rtl/spi_fifo_queue.sv
module spi_fifo_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [LW-1:0] cap,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  din_lo,
    input  logic [W-1:0]  din_hi,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nxt,
    output logic [1:0]    acc_n,
    output logic          pop_ok
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [LW-1:0]           lvl;
    } qstate_t;

    qstate_t st_q, st_d;
    logic [LW-1:0] room;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        room   = (st_q.lvl < cap) ? cap - st_q.lvl : '0;
        if (push_n == 2'd2 && room >= LW'(2))
            acc_n = 2'd2;
        else if (push_n != 2'd0 && room != '0)
            acc_n = 2'd1;
        else
            acc_n = 2'd0;
        pop_ok = pop && (st_q.lvl != '0);
        if (acc_n != 2'd0)
            st_d.mem[st_q.wp] = din_lo;
        if (acc_n == 2'd2)
            st_d.mem[nxt(st_q.wp)] = din_hi;
        if (acc_n == 2'd2)
            st_d.wp = nxt(nxt(st_q.wp));
        else if (acc_n == 2'd1)
            st_d.wp = nxt(st_q.wp);
        if (pop_ok)
            st_d.rp = nxt(st_q.rp);
        st_d.lvl = st_q.lvl + LW'(acc_n) - LW'(pop_ok);
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head      = st_q.mem[st_q.rp];
    assign level     = st_q.lvl;
    assign level_nxt = st_d.lvl;

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= cap);

    assert_no_silent_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !pop) |=> level >= $past(level));

endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_half,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        eng_tx_valid,
    output logic [15:0] eng_tx_data,
    input  logic        eng_tx_pop,
    input  logic        eng_rx_push,
    input  logic [15:0] eng_rx_data,
    output logic        irq
);
    import spi_fifo_pkg::*;

    typedef struct packed {
        logic        fifo_on;
        mode_t       mode;
        logic [31:0] sticky;
        logic [31:0] ien;
    } regs_t;

    regs_t r_q, r_d;

    logic          wr_cmd, wr_mode, wr_ieset, wr_ieclr, wr_txd, rd_stat, rd_rxd;
    logic          tx_clr, rx_clr;
    logic [LW-1:0] cap;
    logic [1:0]    tx_push_n;
    logic [15:0]   tx_head, rx_head;
    logic [LW-1:0] tx_lvl, rx_lvl, tx_lvl_nxt, rx_lvl_nxt;
    logic [1:0]    tx_acc, rx_acc;
    logic          tx_pop_ok, rx_pop_ok;
    logic [31:0]   stat_word, set_ev;

    assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
    assign wr_mode  = bus_wr && (bus_addr == OFS_MODE);
    assign wr_ieset = bus_wr && (bus_addr == OFS_IESET);
    assign wr_ieclr = bus_wr && (bus_addr == OFS_IECLR);
    assign wr_txd   = bus_wr && (bus_addr == OFS_TXD);
    assign rd_stat  = bus_rd && (bus_addr == OFS_STAT);
    assign rd_rxd   = bus_rd && (bus_addr == OFS_RXD);

    assign tx_clr    = wr_cmd && (bus_wdata[CMD_TXCLR] || bus_wdata[CMD_ON] || bus_wdata[CMD_OFF]);
    assign rx_clr    = wr_cmd && (bus_wdata[CMD_RXCLR] || bus_wdata[CMD_ON] || bus_wdata[CMD_OFF]);
    assign cap       = r_q.fifo_on ? LW'(DEPTH) : LW'(1);
    assign tx_push_n = !wr_txd ? 2'd0 : (bus_half ? 2'd1 : 2'd2);

    spi_fifo_queue #(.DEPTH(DEPTH), .W(16)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap(cap),
        .push_n(tx_push_n), .din_lo(bus_wdata[15:0]), .din_hi(bus_wdata[31:16]),
        .pop(eng_tx_pop), .head(tx_head), .level(tx_lvl), .level_nxt(tx_lvl_nxt),
        .acc_n(tx_acc), .pop_ok(tx_pop_ok)
    );

    spi_fifo_queue #(.DEPTH(DEPTH), .W(16)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap(cap),
        .push_n({1'b0, eng_rx_push}), .din_lo(eng_rx_data), .din_hi(16'h0),
        .pop(rd_rxd), .head(rx_head), .level(rx_lvl), .level_nxt(rx_lvl_nxt),
        .acc_n(rx_acc), .pop_ok(rx_pop_ok)
    );

    always_comb begin
        stat_word            = r_q.sticky;
        stat_word[ST_TXEMP]  = (tx_lvl == '0);
        stat_word[ST_TXFUL]  = (tx_lvl == cap);
        stat_word[ST_RXEMP]  = (rx_lvl == '0);
        stat_word[ST_RXFUL]  = (rx_lvl == cap);
    end

    always_comb begin
        r_d    = r_q;
        set_ev = '0;
        set_ev[ST_TXPTR] = wr_txd && (tx_acc != tx_push_n);
        set_ev[ST_RXPTR] = rd_rxd && !rx_pop_ok;
        set_ev[ST_OVR]   = eng_rx_push && (rx_acc == 2'd0);
        set_ev[ST_TXTHR] = (int'(tx_lvl) > int'(r_q.mode.tx_thr)) &&
                           (int'(tx_lvl_nxt) <= int'(r_q.mode.tx_thr));
        set_ev[ST_RXTHR] = (r_q.mode.rx_thr != '0) &&
                           (int'(rx_lvl) < int'(r_q.mode.rx_thr)) &&
                           (int'(rx_lvl_nxt) >= int'(r_q.mode.rx_thr));
        if (rd_stat)
            r_d.sticky = r_q.sticky & ~STICKY_BITS;
        r_d.sticky = r_d.sticky | set_ev;
        if (wr_cmd) begin
            if (bus_wdata[CMD_OFF])     r_d.fifo_on = 1'b0;
            else if (bus_wdata[CMD_ON]) r_d.fifo_on = 1'b1;
        end
        if (wr_mode) begin
            r_d.mode.tx_rdy_mode = bus_wdata[1:0];
            r_d.mode.rx_rdy_mode = bus_wdata[5:4];
            r_d.mode.tx_thr      = bus_wdata[21:16];
            r_d.mode.rx_thr      = bus_wdata[29:24];
        end
        if (wr_ieset) r_d.ien = r_q.ien | (bus_wdata & STICKY_BITS);
        if (wr_ieclr) r_d.ien = r_q.ien & ~bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_MODE:  bus_rdata = {2'b0, r_q.mode.rx_thr, 2'b0, r_q.mode.tx_thr,
                                    10'b0, r_q.mode.rx_rdy_mode, 2'b0, r_q.mode.tx_rdy_mode};
            OFS_STAT:  bus_rdata = stat_word;
            OFS_LVL:   bus_rdata = {10'b0, 6'(rx_lvl), 10'b0, 6'(tx_lvl)};
            OFS_IEVAL: bus_rdata = r_q.ien;
            OFS_RXD:   bus_rdata = (rx_lvl != '0) ? {16'h0, rx_head} : 32'h0;
            default:   bus_rdata = 32'h0;
        endcase
    end

    assign eng_tx_valid = (tx_lvl != '0);
    assign eng_tx_data  = eng_tx_valid ? tx_head : 16'h0;
    assign irq          = |(r_q.sticky & r_q.ien);

    assert_tx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD && bus_wdata[CMD_TXCLR]) |=> tx_lvl == '0);

    assert_rx_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CMD && bus_wdata[CMD_RXCLR]) |=> rx_lvl == '0);

    assert_tx_drop_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_TXD && tx_lvl == cap) |=> r_q.sticky[ST_TXPTR]);

    assert_empty_read_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_RXD && rx_lvl == '0) |=> r_q.sticky[ST_RXPTR]);

    assert_overrun_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_lvl == cap) |=> r_q.sticky[ST_OVR]);

endmodule

// File: tb/spi_fifo_regs_test.sv
module spi_fifo_regs_test;

    localparam int D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_half = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        eng_tx_valid;
    logic [15:0] eng_tx_data;
    logic        eng_tx_pop = 1'b0;
    logic        eng_rx_push = 1'b0;
    logic [15:0] eng_rx_data = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    spi_fifo_regs #(.DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
        .eng_tx_pop(eng_tx_pop), .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic half);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_half = half; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_half = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tx_take(output logic [15:0] d, output logic v);
        @(negedge clk);
        d = eng_tx_data; v = eng_tx_valid; eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic rx_give(input logic [15:0] d);
        @(negedge clk);
        eng_rx_data = d; eng_rx_push = 1'b1;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] d;
        logic        ok;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: R7 status, R5 levels, R6 mode, R13 irq
        rd(8'h08, v); chk("R7 reset status", v, 32'h0900_0000);
        rd(8'h0C, v); chk("R5 reset level", v, 32'h0);
        rd(8'h04, v); chk("R6 reset mode", v, 32'h0);
        chk("R13 reset irq", {31'b0, irq}, 32'h0);

        // R4: single-entry capacity after reset; R9 second push dropped
        wr(8'h1C, 32'h0000_1111, 1'b1);
        wr(8'h1C, 32'h0000_2222, 1'b1);
        rd(8'h0C, v); chk("R4 disabled cap level", v, 32'h1);
        rd(8'h08, v); chk("R9 drop flag", v, 32'h4A00_0000);
        rd(8'h08, v); chk("R12 read clears", v, 32'h0A00_0000);
        tx_take(d, ok); chk("R1 single data", {15'b0, ok, d}, 32'h0001_1111);
        rd(8'h08, v); chk("R8 tx threshold fall to 0", v, 32'h0D00_0000);
        rd(8'h08, v); chk("R12 tx thr cleared", v, 32'h0900_0000);

        // R4 enable full depth; R1 sweep of halfword fills
        wr(8'h00, 32'h4000_0000, 1'b0);
        for (int n = 1; n <= D; n++) begin
            for (int i = 0; i < n; i++) wr(8'h1C, 32'hFFFF_0000 | (32'h100 * n + i), 1'b1);
            rd(8'h0C, v); chk("R5 tx level sweep", v, n);
            for (int i = 0; i < n; i++) begin
                tx_take(d, ok);
                chk("R1 halfword order", {15'b0, ok, d}, 32'h0001_0000 | (32'h100 * n + i));
            end
        end
        tx_take(d, ok); chk("R1 empty tx valid low", {15'b0, ok, d}, 32'h0);

        // R1 32-bit write: low half first
        wr(8'h1C, 32'hBBBB_AAAA, 1'b0);
        rd(8'h0C, v); chk("R1 word push level", v, 32'h2);
        tx_take(d, ok); chk("R1 word low first", {16'h0, d}, 32'hAAAA);
        tx_take(d, ok); chk("R1 word high second", {16'h0, d}, 32'hBBBB);

        // R9 word write with one free slot
        rd(8'h08, v);
        for (int i = 1; i <= 3; i++) wr(8'h1C, 32'h0A00 + i, 1'b1);
        wr(8'h1C, 32'h5555_4444, 1'b0);
        rd(8'h0C, v); chk("R9 partial word level", v, D);
        rd(8'h08, v); chk("R9 partial word flags", v, 32'h4A00_0000);
        for (int i = 1; i <= 3; i++) begin
            tx_take(d, ok); chk("R9 kept items", {16'h0, d}, 32'h0A00 + i);
        end
        tx_take(d, ok); chk("R9 low half kept", {16'h0, d}, 32'h4444);
        tx_take(d, ok); chk("R9 high half dropped", {31'b0, ok}, 32'h0);

        // R3 clears
        wr(8'h1C, 32'h0000_0001, 1'b1);
        wr(8'h1C, 32'h0000_0002, 1'b1);
        for (int i = 0; i < 3; i++) rx_give(16'h0300 + 16'(i));
        rd(8'h0C, v); chk("R5 both levels", v, 32'h0003_0002);
        wr(8'h00, 32'h0001_0000, 1'b0);
        rd(8'h0C, v); chk("R3 tx clear", v, 32'h0003_0000);
        wr(8'h00, 32'h0002_0000, 1'b0);
        rd(8'h0C, v); chk("R3 rx clear", v, 32'h0);

        // R2 receive sweep
        for (int k = 1; k <= D; k++) begin
            for (int i = 0; i < k; i++) rx_give(16'(16'h7000 + 16'h10 * k + i));
            rd(8'h0C, v); chk("R5 rx level sweep", v, k << 16);
            for (int i = 0; i < k; i++) begin
                rd(8'h20, v); chk("R2 rx order", v, 32'h7000 + 32'h10 * k + i);
            end
        end

        // R10 empty read
        rd(8'h08, v);
        rd(8'h20, v); chk("R10 empty read zero", v, 32'h0);
        rd(8'h08, v); chk("R10 empty read flag", v, 32'h8900_0000);

        // R11 overrun
        for (int i = 0; i <= D; i++) rx_give(16'h0E00 + 16'(i));
        rd(8'h0C, v); chk("R11 rx level capped", v, D << 16);
        rd(8'h08, v); chk("R11 overrun flag", v, 32'h1100_0008);
        rd(8'h08, v); chk("R12 overrun cleared", v, 32'h1100_0000);
        for (int i = 0; i < D; i++) begin
            rd(8'h20, v); chk("R11 kept items", v, 32'h0E00 + i);
        end

        // R6 mode layout
        wr(8'h04, 32'hFFFF_FFFF, 1'b0);
        rd(8'h04, v); chk("R6 mode mask", v, 32'h3F3F_0033);
        wr(8'h04, 32'h0300_0000, 1'b0);
        rd(8'h04, v); chk("R6 rx thr", v, 32'h0300_0000);

        // R13 enables
        wr(8'h10, 32'hFFFF_FFFF, 1'b0);
        rd(8'h18, v); chk("R13 enable set", v, 32'hE400_0008);
        wr(8'h14, 32'hFFFF_FFFF, 1'b0);
        wr(8'h10, 32'h2000_0000, 1'b0);
        rd(8'h18, v); chk("R13 enable clear/set", v, 32'h2000_0000);

        // R8 rx threshold and irq
        rd(8'h08, v);
        rx_give(16'h1); rx_give(16'h2);
        chk("R8 below rx thr no irq", {31'b0, irq}, 32'h0);
        rx_give(16'h3);
        chk("R13 irq on rx thr", {31'b0, irq}, 32'h1);
        rd(8'h08, v); chk("R8 rx thr flag", v, 32'h2100_0000);
        chk("R12 irq drops after read", {31'b0, irq}, 32'h0);
        for (int i = 0; i < 3; i++) rd(8'h20, v);

        // R8 tx threshold at 1
        wr(8'h04, 32'h0001_0000, 1'b0);
        rd(8'h08, v);
        for (int i = 0; i < 3; i++) wr(8'h1C, 32'h50 + i, 1'b1);
        rd(8'h08, v); chk("R8 tx rising no flag", v, 32'h0800_0000);
        tx_take(d, ok);
        tx_take(d, ok);
        rd(8'h08, v); chk("R8 tx thr crossing", v, 32'h0C00_0000);
        tx_take(d, ok);
        rd(8'h08, v); chk("R8 no flag below thr", v, 32'h0900_0000);

        // R4 disable empties and restores single capacity
        wr(8'h1C, 32'h0000_0061, 1'b1);
        wr(8'h1C, 32'h0000_0062, 1'b1);
        rx_give(16'h9);
        wr(8'h00, 32'h8000_0000, 1'b0);
        rd(8'h0C, v); chk("R4 disable empties", v, 32'h0);
        wr(8'h1C, 32'h0000_0071, 1'b1);
        wr(8'h1C, 32'h0000_0072, 1'b1);
        rd(8'h0C, v); chk("R4 disabled capacity one", v, 32'h1);
        tx_take(d, ok); chk("R4 disabled holds first", {16'h0, d}, 32'h71);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule